// File: doc/BRIEF.md
# Pseudo-Random Backlight Dimmer

This block sets the brightness of the display and keypad backlight LEDs. It does not use a fixed-period ramp. It compares a programmed 12-bit brightness level against a 4096-state pseudo-random sequence. The resulting on/off pattern has the same average duty ratio as a PWM signal of equal level, but its switching energy is spread across a wide band instead of being concentrated at one tone and its harmonics.

The block runs from a slow clock of about 32 kHz. Software can gate that clock to save power; here this is modelled as a run qualifier on the block clock. While the block is not running, the LED enable output is held low and the sequence generator keeps its state, so the pattern resumes where it stopped. A force-on input bypasses the comparison and drives the LED fully on whenever the block is running. The single output drives the external LED transistor.

Top module: `bkl_dimmer`

## Requirements
- R1: After a synchronous active-low reset, `led_en` is low and the sequence generator holds the seed value 1. With `level`=2 the first running cycle after reset gives a high output, and with `level`=1 it gives a low output.
- R2: While running, the internal sequence passes through all 4096 values from 0 to 4095 and repeats with a period of exactly 4096 running cycles. The output pattern for a fixed level therefore repeats with that period.
- R3: In running cycles, `led_en` is high exactly when the current sequence value is below `level`. As a result, any 4096 consecutive running cycles with a steady `level` contain exactly `level` high cycles. A level of 0 never lights the LED.
- R4: A level of 4095 keeps the LED on in all but one cycle of each 4096-cycle period.
- R5: When `force_on` is 1 and the block is running, `led_en` is high in every cycle, whatever `level` is.
- R6: When `clk_run` is 0, `led_en` is low from the next cycle on, even if `force_on` is 1.
- R7: While `clk_run` is 0, the sequence does not advance. The outputs of the running cycles are identical to those of an uninterrupted run from the same reset.
- R8: `led_en` is registered. A change on `level`, `force_on` or `clk_run` shows on `led_en` after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (the slow backlight clock) |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_run | input | 1 | Clock gate qualifier: 1 runs the block, 0 freezes it |
| level | input | 12 | Brightness level, 0 = off, 4095 = maximum |
| force_on | input | 1 | 1 forces the LED on while running |
| led_en | output | 1 | LED transistor enable |

## Verification
On every cycle, the embedded assertions check the following:
- the sequence register holds while the block is frozen and changes on every running cycle;
- a frozen block gives a low output;
- force-on gives a high output;
- a zero level gives a low output.

Only the bench scenarios can show the exact duty count over a full period for many levels, the 4096-cycle periodicity of the pattern, and that a run interrupted by freezes yields the same enabled-cycle stream as an uninterrupted one.

// File: rtl/bkl_pkg.sv
// Shared constants for the pseudo-random backlight dimmer.
// Assumes a shift-left Fibonacci LFSR whose tap mask includes the MSB.
package bkl_pkg;
    localparam int unsigned DEF_W    = 12;
    // Taps at bits 11, 5, 3, 0: a primitive polynomial of degree 12
    localparam logic [DEF_W-1:0] DEF_TAPS = 12'h829;
    localparam logic [DEF_W-1:0] DEF_SEED = 12'h001;
endpackage

// File: rtl/bkl_seq_gen.sv
// Pseudo-random sequence generator with 2^W states.
// A maximal-length Fibonacci LFSR (2^W-1 states) plus all-zero state
// inserted by flipping the feedback when the low W-1 bits are zero.
// Assumes TAPS has bit W-1 set. Advances only when adv is high.
module bkl_seq_gen #(
    parameter int unsigned W    = bkl_pkg::DEF_W,
    parameter logic [W-1:0] TAPS = bkl_pkg::DEF_TAPS,
    parameter logic [W-1:0] SEED = bkl_pkg::DEF_SEED
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] state
);
    localparam int unsigned LOW_W = W - 1;

    logic fb_lin;
    logic fb;

    // Linear feedback plus the zero-state insertion term
    always_comb begin
        fb_lin = ^(state & TAPS);
        fb     = fb_lin ^ (state[LOW_W-1:0] == '0);
    end

    // Shift register: load seed on reset, shift when advancing
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SEED;
        else if (adv)
            state <= {state[LOW_W-1:0], fb};
    end

    // R7
    hold_when_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(state));

    // R2
    moves_when_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> state != $past(state));
endmodule

// File: rtl/bkl_duty_cmp.sv
// Duty comparator and output register.
// Drives the LED enable high when running and either forced or when the
// current sequence value lies below the programmed level. Low when frozen.
module bkl_duty_cmp #(
    parameter int unsigned W = bkl_pkg::DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         force_on,
    input  logic [W-1:0] level,
    input  logic [W-1:0] seq,
    output logic         led_en
);
    logic below;
    logic led_nxt;

    // Next output value from the comparison and the overrides
    always_comb begin
        below   = (seq < level);
        led_nxt = run & (force_on | below);
    end

    // Registered output so the pin carries no comparator glitches
    always_ff @(posedge clk) begin
        if (!rst_n)
            led_en <= 1'b0;
        else
            led_en <= led_nxt;
    end

    // R6
    frozen_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !led_en);

    // R5
    forced_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && force_on) |=> led_en);

    // R3
    zero_level_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !force_on && level == '0) |=> !led_en);
endmodule

// File: rtl/bkl_dimmer.sv
// Pseudo-random backlight dimmer top.
// Runs from the slow backlight clock; clk_run stands for the software
// clock gate. While frozen the sequence holds and the output is low.
module bkl_dimmer #(
    parameter int unsigned W    = bkl_pkg::DEF_W,
    parameter logic [W-1:0] TAPS = bkl_pkg::DEF_TAPS,
    parameter logic [W-1:0] SEED = bkl_pkg::DEF_SEED
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clk_run,
    input  logic [W-1:0] level,
    input  logic         force_on,
    output logic         led_en
);
    logic [W-1:0] seq;

    // Sequence source, advanced once per running cycle
    bkl_seq_gen #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (clk_run),
        .state (seq)
    );

    // Level comparison and output stage
    bkl_duty_cmp #(.W(W)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (clk_run),
        .force_on (force_on),
        .level    (level),
        .seq      (seq),
        .led_en   (led_en)
    );
endmodule

// File: tb/tb_bkl_dimmer.sv
`timescale 1ns/100ps
module tb_bkl_dimmer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_run = 1'b0;
    logic [11:0] level = '0;
    logic        force_on = 1'b0;
    logic        led_en;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    bkl_dimmer dut (
        .clk(clk), .rst_n(rst_n), .clk_run(clk_run),
        .level(level), .force_on(force_on), .led_en(led_en)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; clk_run = 1'b0; level = '0; force_on = 1'b0;
        repeat (3) @(negedge clk);
        check(led_en == 1'b0, "R1 reset output", led_en, 0);
        rst_n = 1'b1;
    endtask

    // Counts high outputs over one full period of running cycles
    task automatic count_period(input int lv, output int cnt);
        level = 12'(lv); clk_run = 1'b1;
        cnt = 0;
        repeat (4096) begin
            @(negedge clk);
            cnt += int'(led_en);
        end
    endtask

    bit ref_bits [0:299];
    bit per_bits [0:8191];

    initial begin
        int cnt;
        int n;
        int diff;
        // R1: seed value 1 is below level 2 and not below level 1
        do_reset();
        level = 12'd2; clk_run = 1'b1;
        @(negedge clk);
        check(led_en == 1'b1, "R1 seed vs level 2", led_en, 1);
        do_reset();
        level = 12'd1; clk_run = 1'b1;
        @(negedge clk);
        check(led_en == 1'b0, "R1 seed vs level 1", led_en, 0);

        // R3 / R4: exact duty count per 4096-cycle window across levels
        do_reset();
        foreach (per_bits[i]) per_bits[i] = 0;
        begin
            int lvls [15] = '{0, 1, 2, 3, 7, 100, 1000, 2047, 2048, 2049, 3000, 4000, 4093, 4094, 4095};
            foreach (lvls[i]) begin
                count_period(lvls[i], cnt);
                check(cnt == lvls[i], (lvls[i] == 4095) ? "R4 max level count" : "R3 duty count", cnt, lvls[i]);
            end
        end

        // R2: pattern periodicity of 4096
        level = 12'd1500;
        for (int i = 0; i < 8192; i++) begin
            @(negedge clk);
            per_bits[i] = led_en;
        end
        diff = 0;
        for (int i = 0; i < 4096; i++) if (per_bits[i] != per_bits[i+4096]) diff++;
        check(diff == 0, "R2 period 4096 repeat", diff, 0);
        diff = 0;
        for (int i = 0; i < 4096; i++) if (per_bits[i] != per_bits[i+2048]) diff++;
        check(diff != 0, "R2 not period 2048", diff, 1);

        // R5: force overrides any level, including 0
        force_on = 1'b1; level = 12'd0;
        n = 0;
        repeat (200) begin @(negedge clk); n += int'(led_en); end
        check(n == 200, "R5 forced on", n, 200);

        // R6: frozen gives low even while forced
        clk_run = 1'b0;
        n = 0;
        repeat (20) begin @(negedge clk); n += int'(led_en); end
        check(n == 0, "R6 frozen low", n, 0);

        // R8: one-edge latency of level, force and run changes
        force_on = 1'b0; level = 12'd4095; clk_run = 1'b1;
        repeat (5) @(negedge clk);
        level = 12'd0;
        @(negedge clk);
        check(led_en == 1'b0, "R8 level change latency", led_en, 0);
        force_on = 1'b1;
        @(negedge clk);
        check(led_en == 1'b1, "R8 force latency", led_en, 1);
        clk_run = 1'b0;
        @(negedge clk);
        check(led_en == 1'b0, "R8 run latency", led_en, 0);
        force_on = 1'b0;

        // R7: stream with freezes matches an uninterrupted stream
        do_reset();
        level = 12'd1234; clk_run = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            ref_bits[i] = led_en;
        end
        do_reset();
        level = 12'd1234;
        n = 0; diff = 0;
        for (int c = 0; n < 300; c++) begin
            clk_run = ((c % 7) != 3) && ((c % 11) != 5);
            @(negedge clk);
            if (clk_run) begin
                if (led_en != ref_bits[n]) diff++;
                n++;
            end else begin
                check(led_en == 1'b0, "R6 frozen cycle low", led_en, 0);
            end
        end
        check(diff == 0, "R7 resume after freeze", diff, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule